// File: doc/BRIEF.md
# Multi-Check Packet Receiver

This block sits at the receiving end of a point-to-point packet link and decides, word by word, whether an incoming packet can be trusted. A packet is a header word, a number of payload words given by the header's length field, and a trailer word carrying a checksum. The header word is protected by a single-error-correcting, double-error-detecting code. The receiver repairs a header with one flipped bit and gives up on a header with two. It then checks that the packet was addressed to this node and that no packet went missing in between. Finally it recomputes the payload checksum and compares it with the trailer.

Payload words are passed downstream one cycle after they arrive, so nothing is buffered. The verdict is one status pulse per packet, issued one cycle after the word that carries the last marker. The pulse carries one flag per failed check and an overall good/bad bit, which downstream logic uses to keep or drop what it has already received. The decoded header fields are held on dedicated outputs for the length of the packet.

Top module: `pkt_rx_checker`

## Requirements
- R1: The header word is laid out as {overall parity [31], check bits [30:26], cmd [25:22], len [21:16], seq [15:8], src [7:4], dst [3:0]}. Data bit j sits at the j-th position of 3..31 that is not a power of two. Check bit i is the XOR of the data bits whose position has bit i set. The overall parity makes the XOR of all 32 bits zero. Any single flipped bit of the header is corrected, and the verdict sets flag bit 0.
- R2: A header with two flipped bits makes the verdict carry flag bit 1 alone. No payload word is forwarded, and every word up to the last marker is discarded.
- R3: A decodable header whose dst differs from the parameter MY_ID (default 5) sets flag bit 2.
- R4: The expected sequence number is 0 after reset. A decodable header addressed to this node whose seq differs from the expected value sets flag bit 3. After every such header, the expected value becomes seq+1 (mod 256), so one lost packet raises exactly one error.
- R5: A misrouted packet (flag bit 2) leaves the expected sequence number unchanged.
- R6: The payload CRC uses polynomial 0x1021 with initial value 0xFFFF, no reflection and no final XOR. It is fed each payload word MSB first. The trailer's bits [15:0] must equal this CRC; a mismatch sets flag bit 4.
- R7: If the last marker comes with a word other than the one following exactly len payload words, flag bit 5 is set and the CRC is not judged. This covers the header itself, a payload word, or a word after the trailer position.
- R8: Each payload word appears on pl_data with pl_valid one cycle after it is accepted. Header, trailer and surplus words are never forwarded. Cycles with in_valid low are ignored.
- R9: Exactly one st_valid pulse follows each word that carries in_last, one cycle later. st_ok is high in that pulse exactly when no flag other than bit 0 is set. st_flags and st_ok are zero outside the pulse.
- R10: The hdr_* outputs show the corrected fields of the current packet from the cycle after a decodable header until the next one.
- R11: Reset clears all outputs, returns to waiting for a header, resets the expected sequence number to 0, and abandons any packet in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Link word valid |
| in_data | input | 32 | Link word |
| in_last | input | 1 | Marks the final word of a packet |
| pl_valid | output | 1 | Forwarded payload word valid |
| pl_data | output | 32 | Forwarded payload word |
| hdr_dst | output | 4 | Destination field of current packet |
| hdr_src | output | 4 | Source field of current packet |
| hdr_seq | output | 8 | Sequence field of current packet |
| hdr_len | output | 6 | Payload length of current packet |
| hdr_cmd | output | 4 | Command field of current packet |
| st_valid | output | 1 | Verdict pulse |
| st_ok | output | 1 | Packet accepted |
| st_flags | output | 6 | Error flags: 0 corrected, 1 fatal header, 2 route, 3 sequence, 4 CRC, 5 length |

## Verification
Every result is one register stage behind its cause. A payload word shows up one cycle after it is accepted, the verdict one cycle after the word carrying the last marker, and the header fields one cycle after the header. The bench drives inputs on falling edges and records outputs on every falling edge. The verdict it checks is therefore the one registered at the rising edge that took the last word, and each forwarded word is the one taken at the edge before. Each packet is followed by two idle cycles before any comparison, so the count of forwarded words and of verdict pulses is complete.

// File: rtl/prx_pkg.sv
`timescale 1ns/1ps
package prx_pkg;

  localparam int NFLAG   = 6;
  localparam int F_CORR  = 0;
  localparam int F_FATAL = 1;
  localparam int F_ROUTE = 2;
  localparam int F_SEQ   = 3;
  localparam int F_CRC   = 4;
  localparam int F_LEN   = 5;

  localparam int          CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_PAY,
    ST_TRL,
    ST_DRAIN
  } rx_state_e;

  // Number of Hamming check bits needed for k data bits.
  function automatic int chk_width(input int k);
    int p;
    p = 0;
    while ((1 << p) < (k + p + 1)) p++;
    return p;
  endfunction

endpackage

// File: rtl/prx_secded_dec.sv
`timescale 1ns/1ps
module prx_secded_dec #(
  parameter int K     = 26,
  parameter int CHK_W = 5,
  localparam int N    = K + CHK_W + 1
) (
  input  logic [N-1:0] word_i,
  output logic [K-1:0] data_o,
  output logic         corr_o,
  output logic         fatal_o
);

  // Position in the Hamming codeword of data bit j (skips powers of two).
  function automatic logic [CHK_W-1:0] pos_of(input int j);
    int c;
    logic [CHK_W-1:0] r;
    c = 0;
    r = '0;
    for (int p = 3; p < (1 << CHK_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (c == j) r = CHK_W'(p);
        c++;
      end
    end
    return r;
  endfunction

  logic [K-1:0]     data_r;
  logic [CHK_W-1:0] chk_r;
  logic [CHK_W-1:0] chk_calc;
  logic [CHK_W-1:0] syn;
  logic             par_odd;

  assign data_r  = word_i[K-1:0];
  assign chk_r   = word_i[K+CHK_W-1:K];
  assign par_odd = ^word_i;

  always_comb begin
    chk_calc = '0;
    for (int j = 0; j < K; j++) begin
      for (int i = 0; i < CHK_W; i++) begin
        if (pos_of(j)[i]) chk_calc[i] = chk_calc[i] ^ data_r[j];
      end
    end
  end

  assign syn = chk_calc ^ chk_r;

  always_comb begin
    data_o = data_r;
    for (int j = 0; j < K; j++) begin
      if (par_odd && (syn == pos_of(j))) data_o[j] = ~data_r[j];
    end
  end

  assign corr_o  = par_odd;
  assign fatal_o = !par_odd && (syn != '0);

endmodule

// File: rtl/prx_crc16.sv
`timescale 1ns/1ps
module prx_crc16 #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  output logic [15:0]   crc_o
);
  import prx_pkg::*;

  logic [CRC_W-1:0] crc_q, crc_step, crc_d;

  always_comb begin
    crc_step = crc_q;
    for (int b = DW - 1; b >= 0; b--) begin
      if (crc_step[CRC_W-1] ^ data_i[b])
        crc_step = {crc_step[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else
        crc_step = {crc_step[CRC_W-2:0], 1'b0};
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (clr_i)     crc_d = CRC_INIT;
    else if (en_i) crc_d = crc_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/prx_ctrl.sv
`timescale 1ns/1ps
module prx_ctrl #(
  parameter int              ID_W  = 4,
  parameter int              SEQ_W = 8,
  parameter int              LEN_W = 6,
  parameter int              CMD_W = 4,
  parameter logic [ID_W-1:0] MY_ID = 5,
  parameter int              DW    = 32,
  localparam int HDR_W = 2*ID_W + SEQ_W + LEN_W + CMD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             hdr_corr_i,
  input  logic             hdr_fatal_i,
  input  logic [15:0]      crc_i,
  output logic             crc_clr_o,
  output logic             crc_en_o,
  output logic             pl_valid_o,
  output logic [DW-1:0]    pl_data_o,
  output logic [ID_W-1:0]  hdr_dst_o,
  output logic [ID_W-1:0]  hdr_src_o,
  output logic [SEQ_W-1:0] hdr_seq_o,
  output logic [LEN_W-1:0] hdr_len_o,
  output logic [CMD_W-1:0] hdr_cmd_o,
  output logic             st_valid_o,
  output logic             st_ok_o,
  output logic [5:0]       st_flags_o
);
  import prx_pkg::*;

  localparam int SRC_LO = ID_W;
  localparam int SEQ_LO = 2*ID_W;
  localparam int LEN_LO = SEQ_LO + SEQ_W;
  localparam int CMD_LO = LEN_LO + LEN_W;
  localparam logic [NFLAG-1:0] BAD_MASK = ~(NFLAG'(1) << F_CORR);

  // header field slices of the corrected header
  logic [ID_W-1:0]  f_dst, f_src;
  logic [SEQ_W-1:0] f_seq;
  logic [LEN_W-1:0] f_len;
  logic [CMD_W-1:0] f_cmd;

  assign f_dst = hdr_i[ID_W-1:0];
  assign f_src = hdr_i[SRC_LO +: ID_W];
  assign f_seq = hdr_i[SEQ_LO +: SEQ_W];
  assign f_len = hdr_i[LEN_LO +: LEN_W];
  assign f_cmd = hdr_i[CMD_LO +: CMD_W];

  rx_state_e        state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [LEN_W-1:0] len_q, len_d;
  logic [SEQ_W-1:0] exp_q, exp_d;
  logic [NFLAG-1:0] flags_q, flags_d, hflags;
  logic             hdr_load, pl_load;
  logic             st_valid_d, st_ok_d;
  logic [NFLAG-1:0] st_flags_d;

  logic             pl_valid_q;
  logic [DW-1:0]    pl_data_q;
  logic [ID_W-1:0]  dst_q, src_q;
  logic [SEQ_W-1:0] seq_q;
  logic [LEN_W-1:0] hlen_q;
  logic [CMD_W-1:0] cmd_q;
  logic             st_valid_q, st_ok_q;
  logic [NFLAG-1:0] st_flags_q;

  assign cnt_inc = cnt_q + LEN_W'(1);

  // next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    len_d      = len_q;
    exp_d      = exp_q;
    flags_d    = flags_q;
    hflags     = '0;
    hdr_load   = 1'b0;
    pl_load    = 1'b0;
    crc_clr_o  = 1'b0;
    crc_en_o   = 1'b0;
    st_valid_d = 1'b0;
    st_flags_d = '0;
    if (in_valid) begin
      unique case (state_q)
        ST_HDR: begin
          crc_clr_o = 1'b1;
          cnt_d     = '0;
          if (hdr_fatal_i) begin
            hflags[F_FATAL] = 1'b1;
          end else begin
            hflags[F_CORR] = hdr_corr_i;
            hdr_load       = 1'b1;
            len_d          = f_len;
            if (f_dst != MY_ID) begin
              hflags[F_ROUTE] = 1'b1;
            end else begin
              hflags[F_SEQ] = (f_seq != exp_q);
              exp_d         = f_seq + SEQ_W'(1);
            end
          end
          flags_d = hflags;
          if (in_last) begin
            st_valid_d = 1'b1;
            st_flags_d = hflags;
            if (!hdr_fatal_i) st_flags_d[F_LEN] = 1'b1;
          end else if (hdr_fatal_i) begin
            state_d = ST_DRAIN;
          end else if (f_len == '0) begin
            state_d = ST_TRL;
          end else begin
            state_d = ST_PAY;
          end
        end
        ST_PAY: begin
          if (in_last) begin
            st_valid_d        = 1'b1;
            st_flags_d        = flags_q;
            st_flags_d[F_LEN] = 1'b1;
            state_d           = ST_HDR;
          end else begin
            pl_load  = 1'b1;
            crc_en_o = 1'b1;
            cnt_d    = cnt_inc;
            if (cnt_inc == len_q) state_d = ST_TRL;
          end
        end
        ST_TRL: begin
          if (in_last) begin
            st_valid_d        = 1'b1;
            st_flags_d        = flags_q;
            st_flags_d[F_CRC] = (in_data[15:0] != crc_i);
            state_d           = ST_HDR;
          end else begin
            flags_d[F_LEN] = 1'b1;
            state_d        = ST_DRAIN;
          end
        end
        default: begin
          if (in_last) begin
            st_valid_d = 1'b1;
            st_flags_d = flags_q;
            state_d    = ST_HDR;
          end
        end
      endcase
    end
    st_ok_d = st_valid_d && ((st_flags_d & BAD_MASK) == '0);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HDR;
      cnt_q      <= '0;
      len_q      <= '0;
      exp_q      <= '0;
      flags_q    <= '0;
      pl_valid_q <= 1'b0;
      st_valid_q <= 1'b0;
      st_ok_q    <= 1'b0;
      st_flags_q <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      len_q      <= len_d;
      exp_q      <= exp_d;
      flags_q    <= flags_d;
      pl_valid_q <= pl_load;
      st_valid_q <= st_valid_d;
      st_ok_q    <= st_ok_d;
      st_flags_q <= st_flags_d;
    end
  end

  // payload data register, enabled per forwarded word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pl_data_q <= '0;
    else if (pl_load) pl_data_q <= in_data;
  end

  // header field registers, enabled on a decodable header
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q  <= '0;
      src_q  <= '0;
      seq_q  <= '0;
      hlen_q <= '0;
      cmd_q  <= '0;
    end else if (hdr_load) begin
      dst_q  <= f_dst;
      src_q  <= f_src;
      seq_q  <= f_seq;
      hlen_q <= f_len;
      cmd_q  <= f_cmd;
    end
  end

  assign pl_valid_o = pl_valid_q;
  assign pl_data_o  = pl_data_q;
  assign hdr_dst_o  = dst_q;
  assign hdr_src_o  = src_q;
  assign hdr_seq_o  = seq_q;
  assign hdr_len_o  = hlen_q;
  assign hdr_cmd_o  = cmd_q;
  assign st_valid_o = st_valid_q;
  assign st_ok_o    = st_ok_q;
  assign st_flags_o = st_flags_q;

endmodule

// File: rtl/pkt_rx_checker.sv
`timescale 1ns/1ps
module pkt_rx_checker #(
  parameter int              ID_W  = 4,
  parameter int              SEQ_W = 8,
  parameter int              LEN_W = 6,
  parameter int              CMD_W = 4,
  parameter logic [ID_W-1:0] MY_ID = 5,
  localparam int HDR_W = 2*ID_W + SEQ_W + LEN_W + CMD_W,
  localparam int CHK_W = prx_pkg::chk_width(HDR_W),
  localparam int DW    = HDR_W + CHK_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  output logic             pl_valid,
  output logic [DW-1:0]    pl_data,
  output logic [ID_W-1:0]  hdr_dst,
  output logic [ID_W-1:0]  hdr_src,
  output logic [SEQ_W-1:0] hdr_seq,
  output logic [LEN_W-1:0] hdr_len,
  output logic [CMD_W-1:0] hdr_cmd,
  output logic             st_valid,
  output logic             st_ok,
  output logic [5:0]       st_flags
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [HDR_W-1:0] hdr_fix;
  logic             hdr_corr, hdr_fatal;
  logic             crc_clr, crc_en;
  logic [15:0]      crc_val;

  prx_secded_dec #(
    .K     (HDR_W),
    .CHK_W (CHK_W)
  ) u_dec (
    .word_i  (in_data),
    .data_o  (hdr_fix),
    .corr_o  (hdr_corr),
    .fatal_o (hdr_fatal)
  );

  prx_crc16 #(
    .DW (DW)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .data_i (in_data),
    .crc_o  (crc_val)
  );

  prx_ctrl #(
    .ID_W  (ID_W),
    .SEQ_W (SEQ_W),
    .LEN_W (LEN_W),
    .CMD_W (CMD_W),
    .MY_ID (MY_ID),
    .DW    (DW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .hdr_i       (hdr_fix),
    .hdr_corr_i  (hdr_corr),
    .hdr_fatal_i (hdr_fatal),
    .crc_i       (crc_val),
    .crc_clr_o   (crc_clr),
    .crc_en_o    (crc_en),
    .pl_valid_o  (pl_valid),
    .pl_data_o   (pl_data),
    .hdr_dst_o   (hdr_dst),
    .hdr_src_o   (hdr_src),
    .hdr_seq_o   (hdr_seq),
    .hdr_len_o   (hdr_len),
    .hdr_cmd_o   (hdr_cmd),
    .st_valid_o  (st_valid),
    .st_ok_o     (st_ok),
    .st_flags_o  (st_flags)
  );

endmodule

// File: rtl/prx_checker.sv
`timescale 1ns/1ps
module prx_checker #(
  parameter int SEQ_W = 8,
  parameter int CMD_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             pl_valid,
  input logic [SEQ_W-1:0] hdr_seq,
  input logic [CMD_W-1:0] hdr_cmd,
  input logic             st_valid,
  input logic             st_ok,
  input logic [5:0]       st_flags
);

  AST_VERDICT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> st_valid); // R9

  AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(in_valid && in_last)); // R9

  AST_QUIET_OUTSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> (st_flags == 6'd0 && !st_ok)); // R9

  AST_FATAL_STANDS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_flags[1]) |-> (st_flags[5:2] == 4'd0 && !st_flags[0] && !st_ok)); // R2

  AST_NO_FORWARD_OF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> $past(in_valid && !in_last)); // R8

  AST_HDR_HELD_IN_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> ($stable(hdr_seq) && $stable(hdr_cmd))); // R10

  AST_NO_PAYLOAD_WITH_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> !st_valid); // R8

endmodule

bind pkt_rx_checker prx_checker #(
  .SEQ_W (SEQ_W),
  .CMD_W (CMD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .in_last  (in_last),
  .pl_valid (pl_valid),
  .hdr_seq  (hdr_seq),
  .hdr_cmd  (hdr_cmd),
  .st_valid (st_valid),
  .st_ok    (st_ok),
  .st_flags (st_flags)
);

// File: tb/tb_pkt_rx_checker.sv
`timescale 1ns/1ps
module tb_pkt_rx_checker;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_last;
  logic        pl_valid;
  logic [31:0] pl_data;
  logic [3:0]  hdr_dst, hdr_src, hdr_cmd;
  logic [7:0]  hdr_seq;
  logic [5:0]  hdr_len;
  logic        st_valid, st_ok;
  logic [5:0]  st_flags;

  pkt_rx_checker dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .pl_valid (pl_valid),
    .pl_data  (pl_data),
    .hdr_dst  (hdr_dst),
    .hdr_src  (hdr_src),
    .hdr_seq  (hdr_seq),
    .hdr_len  (hdr_len),
    .hdr_cmd  (hdr_cmd),
    .st_valid (st_valid),
    .st_ok    (st_ok),
    .st_flags (st_flags)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: record forwarded words and verdict pulses on falling edges
  logic [31:0] rx_buf [64];
  int          rx_cnt = 0;
  int          st_cnt = 0;
  logic [5:0]  st_f;
  logic        st_o;

  always @(negedge clk) begin
    if (pl_valid) begin
      if (rx_cnt < 64) rx_buf[rx_cnt] = pl_data;
      rx_cnt++;
    end
    if (st_valid) begin
      st_cnt++;
      st_f = st_flags;
      st_o = st_ok;
    end
  end

  // independent header encoder: XOR each set data bit's position into the checks
  function automatic logic [31:0] enc_hdr(input logic [25:0] d);
    logic [4:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 3; p < 32; p++) begin
      if (p != 4 && p != 8 && p != 16) begin
        if (d[j]) c = c ^ 5'(p);
        j++;
      end
    end
    return {^{c, d}, c, d};
  endfunction

  function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int b = 31; b >= 0; b--) begin
      fb = r[15] ^ w[b];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [31:0] pl_word(input int vi, input int w);
    return (32'(vi) * 32'h01010101) ^ (32'(w) * 32'h9E3779B1) ^ 32'h5A00_00C3;
  endfunction

  function automatic string flag_req(input int k);
    case (k)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input logic v, input logic [31:0] d, input logic l);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    in_last  = l;
  endtask

  // lm: 0 exact length, 1 one word short, 2 one word long, 3 header carries last
  task automatic send_packet(input int vi, input logic [3:0] dst, input logic [7:0] seq,
                             input logic [5:0] len, input int fa, input int fb,
                             input bit crcbad, input int lm, input logic [5:0] expf);
    logic [3:0]  cmd;
    logic [3:0]  src;
    logic [31:0] hw;
    logic [15:0] crc;
    int nw, exp_fwd;
    bit fatal;
    cmd   = 4'(vi) ^ 4'h6;
    src   = 4'h9;
    fatal = expf[1];
    hw = enc_hdr({cmd, len, seq, src, dst});
    if (fa < 32) hw[fa] = ~hw[fa];
    if (fb < 32) hw[fb] = ~hw[fb];
    rx_cnt = 0;
    st_cnt = 0;
    drive(1'b1, hw, lm == 3);
    if (lm != 3) begin
      drive(1'b0, 32'hFFFF_FFFF, 1'b1);   // idle cycle inside the packet
      nw  = (lm == 1) ? int'(len) - 1 : int'(len);
      crc = 16'hFFFF;
      for (int w = 0; w < nw; w++) begin
        drive(1'b1, pl_word(vi, w), 1'b0);
        crc = crc_word(crc, pl_word(vi, w));
      end
      if (lm == 2) drive(1'b1, 32'hDEAD_BEEF, 1'b0);
      drive(1'b1, {16'h0, crc ^ {15'd0, crcbad}}, 1'b1);
    end else begin
      nw = 0;
    end
    drive(1'b0, 32'h0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R9", $sformatf("pkt %0d verdict pulses", vi), st_cnt, 1);
    for (int k = 0; k < 6; k++)
      chk(flag_req(k), $sformatf("pkt %0d flag bit %0d", vi, k), st_f[k], expf[k]);
    chk("R9", $sformatf("pkt %0d ok bit", vi), st_o, (expf[5:1] == 5'd0));
    exp_fwd = fatal ? 0 : nw;
    chk("R8", $sformatf("pkt %0d forwarded words", vi), rx_cnt, exp_fwd);
    if (rx_cnt == exp_fwd) begin
      for (int w = 0; w < exp_fwd; w++)
        chk("R8", $sformatf("pkt %0d word %0d", vi, w), rx_buf[w], pl_word(vi, w));
    end
    if (!fatal) begin
      chk("R10", $sformatf("pkt %0d header fields", vi),
          {8'h0, hdr_cmd, hdr_len, hdr_seq, hdr_src, hdr_dst},
          {8'h0, cmd, len, seq, src, dst});
    end
  endtask

  // {exp flags[47:42], dst[41:38], seq[37:30], len[29:24], flipA[23:18],
  //  flipB[17:12], crcbad[11], lenmode[10:9]}; flip index 63 means none
  localparam int NV = 13;
  localparam logic [47:0] VEC [NV] = '{
    {6'h00, 4'd5, 8'd0,  6'd3, 6'd63, 6'd63, 1'b0, 2'd0, 9'd0},  // clean
    {6'h00, 4'd5, 8'd1,  6'd0, 6'd63, 6'd63, 1'b0, 2'd0, 9'd0},  // empty payload
    {6'h01, 4'd5, 8'd2,  6'd4, 6'd7,  6'd63, 1'b0, 2'd0, 9'd0},  // R1 data bit
    {6'h01, 4'd5, 8'd3,  6'd2, 6'd31, 6'd63, 1'b0, 2'd0, 9'd0},  // R1 overall parity
    {6'h02, 4'd5, 8'd4,  6'd2, 6'd3,  6'd9,  1'b0, 2'd0, 9'd0},  // R2 double error
    {6'h10, 4'd5, 8'd4,  6'd2, 6'd63, 6'd63, 1'b1, 2'd0, 9'd0},  // R6 bad CRC
    {6'h08, 4'd5, 8'd7,  6'd1, 6'd63, 6'd63, 1'b0, 2'd0, 9'd0},  // R4 gap
    {6'h00, 4'd5, 8'd8,  6'd1, 6'd63, 6'd63, 1'b0, 2'd0, 9'd0},  // R4 resync
    {6'h04, 4'd3, 8'd9,  6'd2, 6'd63, 6'd63, 1'b0, 2'd0, 9'd0},  // R3 misrouted
    {6'h20, 4'd5, 8'd9,  6'd3, 6'd63, 6'd63, 1'b0, 2'd1, 9'd0},  // R5 seq kept, R7 short
    {6'h20, 4'd5, 8'd10, 6'd2, 6'd63, 6'd63, 1'b0, 2'd2, 9'd0},  // R7 long
    {6'h11, 4'd5, 8'd11, 6'd5, 6'd27, 6'd63, 1'b1, 2'd0, 9'd0},  // R1 check bit + R6
    {6'h10, 4'd5, 8'd12, 6'd0, 6'd63, 6'd63, 1'b1, 2'd0, 9'd0}   // R6 empty payload
  };

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    in_last  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    chk("R11", "pl_valid after reset", pl_valid, 0);
    chk("R11", "st_valid after reset", st_valid, 0);
    chk("R11", "st_flags after reset", st_flags, 0);

    for (int v = 0; v < NV; v++) begin
      send_packet(v, VEC[v][41:38], VEC[v][37:30], VEC[v][29:24],
                  int'(VEC[v][23:18]), int'(VEC[v][17:12]), VEC[v][11],
                  int'(VEC[v][10:9]), VEC[v][47:42]);
    end

    // R7: last marker on the header itself (expected seq is now 13)
    send_packet(20, 4'd5, 8'd13, 6'd2, 63, 63, 1'b0, 3, 6'h20);

    // R11: reset abandons a packet in progress and restarts the sequence
    drive(1'b1, enc_hdr({4'h1, 6'd3, 8'd14, 4'h9, 4'd5}), 1'b0);
    drive(1'b1, 32'h1234_5678, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    chk("R11", "pl_valid during reset", pl_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "st_valid after mid-packet reset", st_valid, 0);
    send_packet(21, 4'd5, 8'd0, 6'd2, 63, 63, 1'b0, 0, 6'h00);
    chk("R11", "sequence restarted at zero", st_f, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule